// File: doc/BRIEF.md
# Nine-bit multiprocessor serial port

This block is an asynchronous serial transceiver. Each frame it sends or receives is eleven bits long: a low start bit, eight data bits least significant first, a ninth bit set by the host, and a high stop bit. The ninth bit serves either as an address marker in a multidrop network or as a parity bit that the host computes. The transmit side shifts out the byte last written by the host. The receive side oversamples its line sixteen times per bit and shifts the incoming bits into a nine-bit register.

The receiver keeps or drops each whole frame through an acceptance filter. A frame is kept only if the receive flag is still clear and, when address filtering is on, the ninth bit is 1. If the filter rejects a frame, no buffer and no flag changes. The bit clock has two sources. In fixed mode it is the system clock divided by 64, or by 32 when the fast-rate input is high. In timer mode it is an external overflow tick divided by 16, and the transmitter and the receiver each choose one of two tick inputs. The transmit-done flag and the receive flag are ORed into one interrupt line. Each flag stays set until the host pulses its clear strobe.

Top module: `ser9_port`

## Requirements
- R1: A transmitted frame is start (0), txData bit 0 through bit 7, then the txNinth value that was captured with the write, then stop (1).
- R2: txd is 1 whenever no frame is being sent. A write to the transmit buffer starts the start bit at the next bit-clock boundary, no more than one bit period after the write.
- R3: txFlag goes to 1 in the cycle in which txd begins the stop bit. It then stays at 1 until a txClear pulse, after which it reads 0.
- R4: With timerMode=0, one bit lasts 64 clock cycles when fastRate=0 and 32 clock cycles when fastRate=1.
- R5: With timerMode=1, one bit lasts 16 pulses of the selected tick. txSelB picks the source for transmit and rxSelB picks it for receive, each on its own (0 = tickA, 1 = tickB).
- R6: A received frame is accepted when rxFlag is 0 at the stop-bit decision and either addrFilter is 0 or the received ninth bit is 1. On acceptance, rxData takes the eight data bits, rxNinth takes the ninth bit, and rxFlag goes to 1.
- R7: A rejected frame leaves rxData, rxNinth and rxFlag unchanged. A frame is rejected when rxFlag is already 1, or when addrFilter is 1 and the ninth bit is 0.
- R8: After each frame, whether kept or dropped, the receiver looks for the next 1-to-0 edge on rxd. A frame that starts right after the previous stop bit is received.
- R9: Each bit is decided by a majority vote over sub-samples 7, 8 and 9 of its 16. A start bit that votes 1 is taken as a glitch. The receiver then returns to idle and no flag changes.
- R10: irq is 1 exactly when txFlag or rxFlag is 1.
- R11: A rxClear pulse while rxFlag is 1 makes rxFlag read 0 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also the oscillator for the fixed divider |
| rstN | input | 1 | Asynchronous reset, active low |
| timerMode | input | 1 | 0: fixed clock divide; 1: external tick divided by 16 |
| fastRate | input | 1 | Fixed mode only: 1 selects divide by 32, 0 selects divide by 64 |
| txSelB | input | 1 | Timer mode: transmit tick source (0 tickA, 1 tickB) |
| rxSelB | input | 1 | Timer mode: receive tick source (0 tickA, 1 tickB) |
| tickA | input | 1 | First external overflow tick, one-cycle pulse |
| tickB | input | 1 | Second external overflow tick, one-cycle pulse |
| txWrite | input | 1 | Write strobe for the transmit buffer |
| txData | input | 8 | Byte to transmit |
| txNinth | input | 1 | Ninth bit to transmit, captured with txWrite |
| txClear | input | 1 | Clears txFlag |
| rxClear | input | 1 | Clears rxFlag |
| addrFilter | input | 1 | 1: accept only frames whose ninth bit is 1 |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| rxData | output | 8 | Receive buffer |
| rxNinth | output | 1 | Ninth bit of the last accepted frame |
| txFlag | output | 1 | Transmit-done flag |
| rxFlag | output | 1 | Receive flag |
| irq | output | 1 | Combined serial-port interrupt |

## Verification
txd registers the start bit at the first bit boundary after a write, at most one bit period later. Every later bit moves out exactly 16 sample ticks after the one before, and txFlag rises in the same cycle as the stop bit. The bench therefore waits for the falling edge of txd and then samples half a bit in and every full bit after that. It measures bit periods by counting the low cycles of a frame of nine zero bits. A received frame is committed at sub-sample 10 of the stop bit, two synchroniser stages plus about half a bit after the stop bit begins. The bench therefore reads rxData, rxNinth and rxFlag only once it has driven the whole stop bit. irq follows the flags with no delay and is compared against them on every clock.

// File: rtl/ser9_pkg.sv
package ser9_pkg;

  typedef struct packed {
    logic txLoad;
    logic txShift;
    logic tiSet;
    logic rxTake;
    logic rxShift;
    logic rxCommit;
  } ctl_t;

endpackage

// File: rtl/ser9_rate.sv
module ser9_rate #(
  parameter int SLOW_DIV = 4,
  parameter int FAST_DIV = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic timerMode,
  input  logic fastRate,
  input  logic txSelB,
  input  logic rxSelB,
  input  logic tickA,
  input  logic tickB,
  output logic txTick,
  output logic rxTick
);
  localparam int CW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam logic [CW-1:0] SLOW_LIM = CW'(SLOW_DIV - 1);
  localparam logic [CW-1:0] FAST_LIM = CW'(FAST_DIV - 1);

  logic [CW-1:0] divCnt;
  logic [CW-1:0] divLim;
  logic          fixTick;

  assign divLim  = fastRate ? FAST_LIM : SLOW_LIM;
  assign fixTick = (divCnt >= divLim);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (fixTick) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  assign txTick = timerMode ? (txSelB ? tickB : tickA) : fixTick;
  assign rxTick = timerMode ? (rxSelB ? tickB : tickA) : fixTick;

endmodule

// File: rtl/ser9_ctrl.sv
module ser9_ctrl #(
  parameter int SUB_N      = 16,
  parameter int FRAME_BITS = 11
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            txTick,
  input  logic            rxTick,
  input  logic            txWrite,
  input  logic            rxIn,
  input  logic            rxVote,
  input  logic            rxNinthNow,
  input  logic            riFlag,
  input  logic            addrFilter,
  output ser9_pkg::ctl_t  ctl,
  output logic            txBusy
);
  localparam int SW = $clog2(SUB_N);
  localparam int BW = $clog2(FRAME_BITS);
  localparam int MID = SUB_N / 2;
  localparam logic [SW-1:0] SUB_LAST = SW'(SUB_N - 1);
  localparam logic [SW-1:0] TAKE0    = SW'(MID - 1);
  localparam logic [SW-1:0] TAKE1    = SW'(MID);
  localparam logic [SW-1:0] TAKE2    = SW'(MID + 1);
  localparam logic [SW-1:0] DECIDE   = SW'(MID + 2);
  localparam logic [BW-1:0] STOP_B   = BW'(FRAME_BITS - 1);
  localparam logic [BW-1:0] NINTH_B  = BW'(FRAME_BITS - 2);

  // transmit sequencing
  logic [SW-1:0] txSub;
  logic [BW-1:0] txBit;
  logic          txPending;
  logic          txBoundary;

  assign txBoundary = txTick && (txSub == SUB_LAST);

  always_comb begin
    ctl.txLoad  = txBoundary && txPending && (!txBusy || txBit == STOP_B);
    ctl.txShift = txBoundary && txBusy && (txBit != STOP_B);
    ctl.tiSet   = ctl.txShift && (txBit == NINTH_B);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSub     <= '0;
      txBit     <= '0;
      txPending <= 1'b0;
      txBusy    <= 1'b0;
    end else begin
      if (txTick) txSub <= (txSub == SUB_LAST) ? '0 : txSub + 1'b1;
      if (txWrite) txPending <= 1'b1;
      else if (ctl.txLoad) txPending <= 1'b0;
      if (ctl.txLoad) begin
        txBusy <= 1'b1;
        txBit  <= '0;
      end else if (txBoundary && txBusy) begin
        if (txBit == STOP_B) txBusy <= 1'b0;
        else txBit <= txBit + 1'b1;
      end
    end
  end

  // receive sequencing
  logic [SW-1:0] rxSub;
  logic [BW-1:0] rxBit;
  logic          rxBusy;
  logic          rxPrev;
  logic          startEdge;
  logic          atDecide;
  logic          glitch;
  logic          frameEnd;

  assign startEdge = rxTick && !rxBusy && rxPrev && !rxIn;
  assign atDecide  = rxTick && rxBusy && (rxSub == DECIDE);
  assign glitch    = atDecide && (rxBit == '0) && rxVote;
  assign frameEnd  = atDecide && (rxBit == STOP_B);

  always_comb begin
    ctl.rxTake   = rxTick && rxBusy &&
                   ((rxSub == TAKE0) || (rxSub == TAKE1) || (rxSub == TAKE2));
    ctl.rxShift  = atDecide && (rxBit != '0) && (rxBit != STOP_B);
    ctl.rxCommit = frameEnd && !riFlag && (!addrFilter || rxNinthNow);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSub  <= '0;
      rxBit  <= '0;
      rxBusy <= 1'b0;
      rxPrev <= 1'b0;
    end else begin
      if (rxTick) rxPrev <= rxIn;
      if (startEdge) begin
        rxBusy <= 1'b1;
        rxSub  <= '0;
        rxBit  <= '0;
      end else if (rxTick && rxBusy) begin
        if (glitch || frameEnd) rxBusy <= 1'b0;
        rxSub <= (rxSub == SUB_LAST) ? '0 : rxSub + 1'b1;
        if (rxSub == SUB_LAST) rxBit <= rxBit + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ser9_dpath.sv
module ser9_dpath #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ser9_pkg::ctl_t    ctl,
  input  logic              txWrite,
  input  logic [DATA_W-1:0] txData,
  input  logic              txNinth,
  input  logic              txClear,
  input  logic              rxClear,
  input  logic              rxd,
  output logic              txd,
  output logic              rxIn,
  output logic              rxVote,
  output logic              rxNinthNow,
  output logic [DATA_W-1:0] rxData,
  output logic              rxNinth,
  output logic              tiFlag,
  output logic              riFlag
);
  logic [DATA_W-1:0] bufData;
  logic              bufNinth;
  logic [DATA_W+1:0] txSh;
  logic              rxS1;
  logic              rxS2;
  logic [2:0]        takeReg;
  logic [DATA_W:0]   rxSh;

  assign rxIn       = rxS2;
  assign rxVote     = (takeReg[0] & takeReg[1]) | (takeReg[1] & takeReg[2]) |
                      (takeReg[0] & takeReg[2]);
  assign rxNinthNow = rxSh[DATA_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufData  <= '0;
      bufNinth <= 1'b0;
      txSh     <= '1;
      txd      <= 1'b1;
    end else begin
      if (txWrite) begin
        bufData  <= txData;
        bufNinth <= txNinth;
      end
      if (ctl.txLoad) begin
        txSh <= {1'b1, bufNinth, bufData};
        txd  <= 1'b0;
      end else if (ctl.txShift) begin
        txd  <= txSh[0];
        txSh <= {1'b1, txSh[DATA_W+1:1]};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxS1    <= 1'b1;
      rxS2    <= 1'b1;
      takeReg <= '1;
      rxSh    <= '0;
      rxData  <= '0;
      rxNinth <= 1'b0;
    end else begin
      rxS1 <= rxd;
      rxS2 <= rxS1;
      if (ctl.rxTake) takeReg <= {takeReg[1:0], rxIn};
      if (ctl.rxShift) rxSh <= {rxVote, rxSh[DATA_W:1]};
      if (ctl.rxCommit) begin
        rxData  <= rxSh[DATA_W-1:0];
        rxNinth <= rxSh[DATA_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tiFlag <= 1'b0;
      riFlag <= 1'b0;
    end else begin
      if (ctl.tiSet) tiFlag <= 1'b1;
      else if (txClear) tiFlag <= 1'b0;
      if (ctl.rxCommit) riFlag <= 1'b1;
      else if (rxClear) riFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/ser9_port.sv
module ser9_port #(
  parameter int DATA_W   = 8,
  parameter int SUB_N    = 16,
  parameter int SLOW_DIV = 4,
  parameter int FAST_DIV = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              timerMode,
  input  logic              fastRate,
  input  logic              txSelB,
  input  logic              rxSelB,
  input  logic              tickA,
  input  logic              tickB,
  input  logic              txWrite,
  input  logic [DATA_W-1:0] txData,
  input  logic              txNinth,
  input  logic              txClear,
  input  logic              rxClear,
  input  logic              addrFilter,
  input  logic              rxd,
  output logic              txd,
  output logic [DATA_W-1:0] rxData,
  output logic              rxNinth,
  output logic              txFlag,
  output logic              rxFlag,
  output logic              irq
);
  localparam int FRAME_BITS = DATA_W + 3;

  ser9_pkg::ctl_t ctl;
  logic txTick;
  logic rxTick;
  logic rxIn;
  logic rxVote;
  logic rxNinthNow;
  logic txBusy;

  ser9_rate #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_rate (
    .clk(clk), .rstN(rstN), .timerMode(timerMode), .fastRate(fastRate),
    .txSelB(txSelB), .rxSelB(rxSelB), .tickA(tickA), .tickB(tickB),
    .txTick(txTick), .rxTick(rxTick)
  );

  ser9_ctrl #(.SUB_N(SUB_N), .FRAME_BITS(FRAME_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .txTick(txTick), .rxTick(rxTick),
    .txWrite(txWrite), .rxIn(rxIn), .rxVote(rxVote), .rxNinthNow(rxNinthNow),
    .riFlag(rxFlag), .addrFilter(addrFilter), .ctl(ctl), .txBusy(txBusy)
  );

  ser9_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .txWrite(txWrite), .txData(txData),
    .txNinth(txNinth), .txClear(txClear), .rxClear(rxClear), .rxd(rxd),
    .txd(txd), .rxIn(rxIn), .rxVote(rxVote), .rxNinthNow(rxNinthNow),
    .rxData(rxData), .rxNinth(rxNinth), .tiFlag(txFlag), .riFlag(rxFlag)
  );

  assign irq = txFlag | rxFlag;

endmodule

// File: rtl/ser9_port_chk.sv
module ser9_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              txd,
  input logic              txFlag,
  input logic              rxFlag,
  input logic [DATA_W-1:0] rxData,
  input logic              rxNinth,
  input logic              addrFilter,
  input logic              txClear,
  input logic              rxClear,
  input logic              txBusy,
  input logic              txLoad,
  input logic              tiSet
);

  assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txd);

  assert_start_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    txLoad |=> !txd);

  assert_ti_on_stop_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txFlag) |-> txd);

  assert_ti_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (txClear && !tiSet) |=> !txFlag);

  assert_accept_filter_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFlag) |-> (!$past(addrFilter) || rxNinth));

  assert_drop_keeps_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(rxData) || !$stable(rxNinth)) |-> $rose(rxFlag));

  assert_ri_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    (rxClear && rxFlag) |=> !rxFlag);

endmodule

bind ser9_port ser9_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .txd(txd), .txFlag(txFlag), .rxFlag(rxFlag),
  .rxData(rxData), .rxNinth(rxNinth), .addrFilter(addrFilter),
  .txClear(txClear), .rxClear(rxClear), .txBusy(txBusy),
  .txLoad(ctl.txLoad), .tiSet(ctl.tiSet)
);

// File: tb/ser9_port_tb.sv
module ser9_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TA = 3;
  localparam int TB = 5;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic timerMode = 1'b0, fastRate = 1'b0, txSelB = 1'b0, rxSelB = 1'b0;
  logic tickA, tickB;
  logic txWrite = 1'b0, txNinth = 1'b0, txClear = 1'b0, rxClear = 1'b0;
  logic addrFilter = 1'b0, rxd = 1'b1;
  logic [7:0] txData = 8'h00;
  logic txd, rxNinth, txFlag, rxFlag, irq;
  logic [7:0] rxData;

  int testCount = 0;
  int failCount = 0;
  int cycles = 0;
  int irqFails = 0;
  bit done = 1'b0;
  int cntA = 0;
  int cntB = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cntA <= (cntA == TA - 1) ? 0 : cntA + 1;
    cntB <= (cntB == TB - 1) ? 0 : cntB + 1;
  end
  assign tickA = (cntA == TA - 1);
  assign tickB = (cntB == TB - 1);

  ser9_port u_dut (
    .clk(clk), .rstN(rstN), .timerMode(timerMode), .fastRate(fastRate),
    .txSelB(txSelB), .rxSelB(rxSelB), .tickA(tickA), .tickB(tickB),
    .txWrite(txWrite), .txData(txData), .txNinth(txNinth), .txClear(txClear),
    .rxClear(rxClear), .addrFilter(addrFilter), .rxd(rxd), .txd(txd),
    .rxData(rxData), .rxNinth(rxNinth), .txFlag(txFlag), .rxFlag(rxFlag),
    .irq(irq)
  );

  // reference for the combined interrupt (R10), compared on every clock
  always @(negedge clk) begin
    if (rstN && (irq !== (txFlag | rxFlag))) irqFails++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG && !done) begin
      failCount++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic waitTxFall(input int limit, output int waited);
    waited = 0;
    while (txd && waited < limit) begin
      @(negedge clk);
      waited++;
    end
  endtask

  task automatic hostWrite(input logic [7:0] d, input logic n);
    txData = d; txNinth = n; txWrite = 1'b1;
    @(negedge clk);
    txWrite = 1'b0;
  endtask

  task automatic clearTi();
    txClear = 1'b1;
    @(negedge clk);
    txClear = 1'b0;
    @(negedge clk);
    check(txFlag == 1'b0, "R3 txFlag cleared", txFlag, 0);
  endtask

  task automatic txFrame(input logic [7:0] d, input logic n, input int bitClk);
    int waited;
    logic [7:0] got;
    hostWrite(d, n);
    waitTxFall(bitClk + 4, waited);
    check(txd == 1'b0, "R2 start within one bit", waited, bitClk);
    repeat (bitClk / 2) @(negedge clk);
    check(txd == 1'b0, "R1 start bit", txd, 0);
    for (int i = 0; i < 8; i++) begin
      repeat (bitClk) @(negedge clk);
      got[i] = txd;
    end
    check(got == d, "R1 data bits", got, d);
    repeat (bitClk) @(negedge clk);
    check(txd == n, "R1 ninth bit", txd, n);
    check(txFlag == 1'b0, "R3 txFlag before stop", txFlag, 0);
    repeat (bitClk) @(negedge clk);
    check(txd == 1'b1, "R1 stop bit", txd, 1);
    check(txFlag == 1'b1, "R3 txFlag at stop", txFlag, 1);
    check(irq == 1'b1, "R10 irq from txFlag", irq, 1);
    repeat (bitClk) @(negedge clk);
    check(txd == 1'b1, "R2 idle high after frame", txd, 1);
    clearTi();
  endtask

  task automatic txPeriod(input int bitClk, input string tag);
    int waited;
    int lowCnt;
    hostWrite(8'h00, 1'b1);
    waitTxFall(bitClk + 4, waited);
    lowCnt = 0;
    while (!txd && lowCnt < 12 * bitClk) begin
      @(negedge clk);
      lowCnt++;
    end
    check(lowCnt == 9 * bitClk, tag, lowCnt, 9 * bitClk);
    repeat (2 * bitClk) @(negedge clk);
    clearTi();
  endtask

  task automatic rxFrame(input logic [7:0] d, input logic n, input int bitClk);
    logic [10:0] bits;
    bits = {1'b1, n, d, 1'b0};
    for (int i = 0; i < 11; i++) begin
      rxd = bits[i];
      repeat (bitClk) @(negedge clk);
    end
  endtask

  task automatic clearRi();
    rxClear = 1'b1;
    @(negedge clk);
    rxClear = 1'b0;
    @(negedge clk);
    check(rxFlag == 1'b0, "R11 rxFlag cleared", rxFlag, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(txd == 1'b1, "R2 reset txd", txd, 1);
    check(txFlag == 1'b0 && rxFlag == 1'b0, "R3 reset flags", {txFlag, rxFlag}, 0);
    check(irq == 1'b0, "R10 reset irq", irq, 0);
    check(rxData == 8'h00, "R6 reset rxData", rxData, 0);
    repeat (100) @(negedge clk);
    check(txd == 1'b1, "R2 idle high", txd, 1);

    // fixed mode, slow then fast
    fastRate = 1'b0;
    txPeriod(64, "R4 slow bit period");
    txFrame(8'hA5, 1'b0, 64);
    fastRate = 1'b1;
    txPeriod(32, "R4 fast bit period");
    txFrame(8'h3C, 1'b1, 32);

    // receive, fast fixed rate
    addrFilter = 1'b0;
    rxFrame(8'h5A, 1'b0, 32);
    check(rxFlag == 1'b1, "R6 rxFlag set", rxFlag, 1);
    check(rxData == 8'h5A, "R6 rxData", rxData, 8'h5A);
    check(rxNinth == 1'b0, "R6 rxNinth", rxNinth, 0);
    check(irq == 1'b1, "R10 irq from rxFlag", irq, 1);
    clearRi();

    // back-to-back: second frame arrives while rxFlag still set
    rxFrame(8'hC3, 1'b1, 32);
    check(rxFlag && rxData == 8'hC3 && rxNinth, "R8 first of pair", rxData, 8'hC3);
    rxFrame(8'h11, 1'b0, 32);
    repeat (32) @(negedge clk);
    check(rxData == 8'hC3, "R7 dropped while rxFlag set", rxData, 8'hC3);
    check(rxNinth == 1'b1, "R7 rxNinth kept", rxNinth, 1);
    clearRi();

    // address filter: ninth 0 dropped, ninth 1 kept right after
    addrFilter = 1'b1;
    rxFrame(8'h77, 1'b0, 32);
    check(rxFlag == 1'b0, "R7 filtered frame no flag", rxFlag, 0);
    check(rxData == 8'hC3, "R7 filtered frame no data", rxData, 8'hC3);
    rxFrame(8'h99, 1'b1, 32);
    check(rxFlag == 1'b1, "R8 accepted after drop", rxFlag, 1);
    check(rxData == 8'h99 && rxNinth == 1'b1, "R6 address frame", rxData, 8'h99);
    clearRi();
    addrFilter = 1'b0;

    // start glitch shorter than half a bit
    rxd = 1'b0;
    repeat (6) @(negedge clk);
    rxd = 1'b1;
    repeat (96) @(negedge clk);
    check(rxFlag == 1'b0, "R9 glitch ignored", rxFlag, 0);
    check(rxData == 8'h99, "R9 glitch keeps data", rxData, 8'h99);
    rxFrame(8'h42, 1'b0, 32);
    check(rxFlag == 1'b1 && rxData == 8'h42, "R9 frame after glitch", rxData, 8'h42);
    clearRi();

    // slow fixed receive
    fastRate = 1'b0;
    rxFrame(8'hE1, 1'b0, 64);
    check(rxFlag == 1'b1 && rxData == 8'hE1, "R4 slow receive", rxData, 8'hE1);
    clearRi();

    // timer mode, separate sources
    timerMode = 1'b1; txSelB = 1'b1; rxSelB = 1'b0;
    txPeriod(16 * TB, "R5 tx on tickB");
    rxFrame(8'h2D, 1'b1, 16 * TA);
    check(rxFlag == 1'b1 && rxData == 8'h2D, "R5 rx on tickA", rxData, 8'h2D);
    clearRi();
    txSelB = 1'b0; rxSelB = 1'b1;
    txPeriod(16 * TA, "R5 tx on tickA");
    rxFrame(8'hB6, 1'b0, 16 * TB);
    check(rxFlag == 1'b1 && rxData == 8'hB6, "R5 rx on tickB", rxData, 8'hB6);
    clearRi();
    txFrame(8'h69, 1'b1, 16 * TA);

    check(irqFails == 0, "R10 irq per-clock compare", irqFails, 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule